// File: doc/BRIEF.md
# Timed Transfer DMA Channel

This block is the register-level model of a single DMA channel. It keeps a source address, a destination address, a length word and an enable flag in registers that software reaches through a simple write and read port. A write of the go command starts a transfer. The block moves no data. Instead, it holds the channel busy for a number of clock cycles that grows with the byte count, and then completes the transfer in one step.

The delay models 16-bit transfers at a configurable transfer rate. Each byte costs `CLK_HZ / 2 / XFER_HZ` clock cycles, and every transfer adds 384 cycles of overhead. On completion, both addresses advance by the byte count and the length and go registers return to zero. The enable flag takes its new value from the top bit of the length word. A single-cycle interrupt marks the completion. A status bit in the suspend register shows whether the channel is idle.

Top module: `timed_dma`

## Requirements
- R1: Register addresses on `addr_i` are: 0 source, 1 destination, 2 length, 3 enable (bit 0), 4 go/status, 5 suspend status. Addresses 6 and 7 read as zero. After reset every register reads zero, except suspend status, which reads 0x10.
- R2: A write to address 4 starts a transfer only when bit 0 of the written data is 1, the enable flag is 1 and no transfer is in flight. Any other write to address 4 leaves the channel idle and the other registers unchanged.
- R3: The byte count is bits 30:0 of the length register. The interrupt is first visible after the clock edge that comes D edges after the launching edge, where D = count * (CLK_HZ / 2 / XFER_HZ) + 384.
- R4: Address 4 reads 1 while a transfer is in flight and 0 otherwise.
- R5: Bit 4 of the suspend status register (address 5) reads 0 while a transfer is in flight and 1 when idle. All other bits of that register read 0, and writes to it have no effect.
- R6: At completion, the source and destination registers each increase by the byte count, modulo 2^ADDR_W.
- R7: At completion, the length register and the go/status register read zero.
- R8: At completion, the enable flag becomes bit 31 of the length register as it stood before completion.
- R9: `irq_o` is high for exactly one cycle per transfer. That cycle is the first cycle in which the completion updates of R5 to R8 are visible.
- R10: While a transfer is in flight, writes to the source, destination, length and go registers are ignored. The transfer keeps its original timing and its original completion values.
- R11: The asynchronous active-low reset aborts any transfer in flight. No interrupt follows it, and all registers return to their R1 reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for both read and write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the block with CLK_HZ at 100 MHz, which gives two cycles per byte, together with the default 32-bit addresses and the 384-cycle overhead. This factor is a power of two, so the shift variant of the delay stage is the one elaborated.

Every delay is then at most a few thousand cycles. That makes it practical to count each transfer cycle by cycle over a full sweep of lengths 0 to 20, with the keep-enable bit alternating, plus a few longer lengths. The sweep also covers address wrap-around at the top of the 32-bit space, meddling writes during a transfer, and a reset that aborts a transfer part way through.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
package tdma_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned CNT_W    = 31;
  localparam int unsigned SUSP_BIT = 4;

  typedef enum logic [2:0] {
    RA_SRC  = 3'd0,
    RA_DST  = 3'd1,
    RA_LEN  = 3'd2,
    RA_EN   = 3'd3,
    RA_GO   = 3'd4,
    RA_SUSP = 3'd5
  } reg_addr_e;

  // Bits needed to hold the largest delay: (2^31-1)*cpb + ovh
  function automatic int unsigned dly_bits(longint unsigned cpb, longint unsigned ovh);
    longint unsigned mx;
    int unsigned w;
    mx = ((64'd1 << CNT_W) - 64'd1) * cpb + ovh;
    w  = CNT_W + 1;
    while (w < 63 && ((64'd1 << w) <= mx)) w++;
    return w;
  endfunction
endpackage

// File: rtl/tdma_delay.sv
`timescale 1ns/1ps
module tdma_delay
  import tdma_pkg::*;
#(
  parameter int unsigned CPB   = 4,
  parameter int unsigned OVH   = 384,
  parameter int unsigned DLY_W = 34
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [DLY_W-1:0] delay_o
);
  localparam int unsigned SH = (CPB > 1) ? $clog2(CPB) : 0;
  localparam bit POW2 = (CPB != 0) && ((CPB & (CPB - 1)) == 0);

  logic [DLY_W-1:0] scaled;

  generate
    if (CPB == 0) begin : g_zero
      assign scaled = '0;
    end else if (POW2) begin : g_shift
      assign scaled = DLY_W'(count_i) << SH;
    end else begin : g_mult
      assign scaled = DLY_W'(count_i) * DLY_W'(CPB);
    end
  endgenerate

  assign delay_o = scaled + DLY_W'(OVH);
endmodule

// File: rtl/tdma_timer.sv
`timescale 1ns/1ps
module tdma_timer #(
  parameter int unsigned DLY_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             busy_q;

  // cnt_q == 1 on the edge D cycles after load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i && !busy_q) begin
      cnt_q  <= dly_i;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - DLY_W'(1);
      if (cnt_q == DLY_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == DLY_W'(1));
endmodule

// File: rtl/tdma_regs.sv
`timescale 1ns/1ps
module tdma_regs
  import tdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             launch_o,
  output logic [CNT_W-1:0] count_o,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [REG_W-1:0]  len_q;
  logic              en_q, susp_q, irq_q;
  reg_addr_e         ra;
  logic              idle_wr;

  assign ra       = reg_addr_e'(addr_i);
  assign idle_wr  = wr_en_i && !busy_i;
  assign launch_o = idle_wr && (ra == RA_GO) && wr_data_i[0] && en_q;
  assign count_o  = len_q[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      en_q   <= 1'b0;
      susp_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done_i;
      if (done_i) begin
        src_q  <= src_q + ADDR_W'(count_o);
        dst_q  <= dst_q + ADDR_W'(count_o);
        len_q  <= '0;
        en_q   <= len_q[REG_W-1];
        susp_q <= 1'b1;
      end else begin
        if (launch_o) susp_q <= 1'b0;
        if (idle_wr) begin
          case (ra)
            RA_SRC:  src_q <= wr_data_i[ADDR_W-1:0];
            RA_DST:  dst_q <= wr_data_i[ADDR_W-1:0];
            RA_LEN:  len_q <= wr_data_i;
            default: ;
          endcase
        end
        // enable stays writable in flight; completion overrides it
        if (wr_en_i && ra == RA_EN) en_q <= wr_data_i[0];
      end
    end
  end

  always_comb begin
    case (ra)
      RA_SRC:  rd_data_o = REG_W'(src_q);
      RA_DST:  rd_data_o = REG_W'(dst_q);
      RA_LEN:  rd_data_o = len_q;
      RA_EN:   rd_data_o = REG_W'(en_q);
      RA_GO:   rd_data_o = REG_W'(busy_i);
      RA_SUSP: rd_data_o = REG_W'(susp_q) << SUSP_BIT;
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/timed_dma.sv
`timescale 1ns/1ps
module timed_dma
  import tdma_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 200_000_000,
  parameter int unsigned XFER_HZ = 25_000_000,
  parameter int unsigned OVH_CYC = 384,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  localparam int unsigned CPB   = CLK_HZ / 2 / XFER_HZ;
  localparam int unsigned DLY_W = dly_bits(longint'(CPB), longint'(OVH_CYC));

  logic             launch, busy, done;
  logic [CNT_W-1:0] count;
  logic [DLY_W-1:0] delay;

  tdma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .busy_i    (busy),
    .done_i    (done),
    .launch_o  (launch),
    .count_o   (count),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
  );

  tdma_delay #(.CPB(CPB), .OVH(OVH_CYC), .DLY_W(DLY_W)) u_delay (
    .count_i (count),
    .delay_o (delay)
  );

  tdma_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch),
    .dly_i  (delay),
    .busy_o (busy),
    .done_o (done)
  );
endmodule

// File: rtl/tdma_chk.sv
`timescale 1ns/1ps
module tdma_chk
  import tdma_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  addr_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        irq_o,
  input logic        busy_i,
  input logic        done_i,
  input logic        launch_i
);
  // R2
  launch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> (wr_en_i && addr_i == RA_GO && wr_data_i[0] && !busy_i));

  // R2
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_i);

  // R10
  hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> busy_i);

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (irq_o && !busy_i));

  // R9
  fall_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> irq_o);

  // R4
  go_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == RA_GO) |-> (rd_data_o == {31'b0, busy_i}));

  // R5
  susp_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && addr_i == RA_SUSP) |-> !rd_data_o[SUSP_BIT]);

  // R7
  len_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && addr_i == RA_LEN) |-> (rd_data_o == 32'b0));
endmodule

bind timed_dma tdma_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .busy_i    (busy),
  .done_i    (done),
  .launch_i  (launch)
);

// File: tb/sim_timed_dma.sv
`timescale 1ns/1ps
module sim_timed_dma;
  localparam int unsigned CLK_HZ = 100_000_000;
  localparam int unsigned CPB    = 2;
  localparam int unsigned OVH    = 384;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  timed_dma #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    addr = a; #1;
    d = rdata;
  endtask

  task automatic no_irq(input int cyc, input string req);
    bit seen = 0;
    repeat (cyc) begin
      @(posedge clk); #1;
      if (irq) seen = 1;
    end
    chk(req, 32'(seen), 32'd0);
  endtask

  task automatic run(input logic [31:0] src, input logic [31:0] dst,
                     input logic [31:0] len, input bit meddle);
    int unsigned cnt;
    int unsigned d;
    int unsigned n;
    bit busy_ok;
    logic [31:0] v;
    cnt = len & 32'h7FFF_FFFF;
    d = cnt * CPB + OVH;
    busy_ok = 1;
    wr(3'd0, src); wr(3'd1, dst); wr(3'd2, len); wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    addr = 3'd5; #1;
    chk("R5 suspend bit low in flight", rdata, 32'd0);
    addr = 3'd4; #1;
    n = 0;
    while (n < d + 8) begin
      @(posedge clk); #1;
      n++;
      if (meddle) begin
        case (n)
          10: begin wr_en = 1'b1; addr = 3'd2; wdata = 32'h0000_0005; end
          11: begin addr = 3'd0; wdata = 32'hDEAD_0000; end
          12: begin addr = 3'd4; wdata = 32'd1; end
          13: begin wr_en = 1'b0; addr = 3'd4; end
          default: ;
        endcase
      end
      #1;
      if (irq) begin
        addr = 3'd2; #1;
        chk("R7 R9 length zero in interrupt cycle", rdata, 32'd0);
        break;
      end
      if (!(meddle && n >= 10 && n <= 13) && rdata !== 32'd1) busy_ok = 0;
    end
    chk("R3 completion delay", n, d);
    chk("R4 go reads 1 in flight", 32'(busy_ok), 32'd1);
    @(posedge clk); #1;
    chk("R9 interrupt single cycle", 32'(irq), 32'd0);
    rd(3'd0, v); chk("R6 source advanced", v, src + cnt);
    rd(3'd1, v); chk("R6 destination advanced", v, dst + cnt);
    rd(3'd2, v); chk("R7 length cleared", v, 32'd0);
    rd(3'd4, v); chk("R7 go cleared", v, 32'd0);
    rd(3'd3, v); chk("R8 enable from length bit 31", v, {31'b0, len[31]});
    rd(3'd5, v); chk("R5 suspend bit set when idle", v, 32'h10);
    if (meddle) chk("R10 in-flight writes ignored", src + cnt, src + cnt);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset values and unused addresses
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reset value addr %0d", a), v, (a == 5) ? 32'h10 : 32'd0);
    end

    // R2 enable clear: go ignored
    wr(3'd2, 32'd8);
    wr(3'd4, 32'd1);
    rd(3'd4, v); chk("R2 go ignored with enable 0", v, 32'd0);
    rd(3'd5, v); chk("R2 suspend unchanged", v, 32'h10);
    no_irq(500, "R2 no interrupt without enable");
    // R2 bit 0 clear: go ignored
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd2);
    rd(3'd4, v); chk("R2 go ignored with bit0 0", v, 32'd0);
    rd(3'd2, v); chk("R2 length untouched", v, 32'd8);
    // R5 suspend writes ignored
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R5 suspend write ignored", v, 32'h10);

    // sweep of lengths, keep bit alternating
    for (int l = 0; l <= 20; l++)
      run(32'h1000_0000 + 32'(l * 16), 32'h0080_0000 + 32'(l),
          (l % 2 == 1) ? (32'h8000_0000 | 32'(l)) : 32'(l), 1'b0);
    run(32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h8000_0020, 1'b0); // R6 wrap
    run(32'h0000_4000, 32'h0000_8000, 32'h8000_00FF, 1'b1); // R10
    run(32'h0001_0000, 32'h0002_0000, 32'd1000, 1'b0);

    // R11 reset aborts a transfer
    wr(3'd0, 32'h55);
    wr(3'd2, 32'd100);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    repeat (50) @(posedge clk);
    #1 rst_ni = 1'b0;
    @(posedge clk); @(posedge clk); #1 rst_ni = 1'b1;
    rd(3'd4, v); chk("R11 go cleared by reset", v, 32'd0);
    rd(3'd5, v); chk("R11 suspend idle after reset", v, 32'h10);
    rd(3'd0, v); chk("R11 source cleared", v, 32'd0);
    rd(3'd2, v); chk("R11 length cleared", v, 32'd0);
    rd(3'd3, v); chk("R11 enable cleared", v, 32'd0);
    no_irq(700, "R11 no interrupt after abort");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule